// File: doc/BRIEF.md
# Latched Serial-to-Parallel Output Register

This block models the logic of a serial-in, parallel-out output expander. Serial data is moved one stage along a chain on every rising edge of a shift clock. A second clock, the register clock, copies the whole chain into a storage register in one step. The storage register feeds a gated output stage that drives one active-high "sink on" line per output, where 1 means the load is switched on.

An active-low clear empties the shift chain at once, without a clock. The storage register is not touched by the clear. An active-low output enable forces every output off while it is high. The last chain stage is brought out as a serial output, so several instances can be daisy-chained and driven from one data line.

The shift clock, register clock and serial data arrive as plain levels. They are sampled by a common system clock, with an optional synchronizer depth, and rising edges are detected against a registered copy. When both clock edges land in the same system cycle, the storage register takes the chain value from before that shift.

Top module: `sipo_latch_driver`

## Requirements
- R1: Each detected rising edge of `shift_clk` moves the chain up by one place, with `ser_in` entering at bit 0. Outputs settle at the system clock edge that samples the rise.
- R2: `ser_out` is chain bit WIDTH-1. The first of WIDTH shifted bits appears on `ser_out` after the WIDTH-th shift.
- R3: Each detected rising edge of `latch_clk` copies the full chain into the storage register. Between such edges the storage register holds its value.
- R4: While `clr_n` is low the chain is zero, with no clock needed, and shift edges have no effect. The storage register and the outputs keep their values.
- R5: While `oe_n` is high, every bit of `sink_on` is 0, whatever the storage register holds.
- R6: While `oe_n` is low, `sink_on` equals the storage register, bit for bit. A stored 1 turns the matching output on.
- R7: When the shift and latch edges are detected in the same cycle, the storage register takes the chain value from before that shift.
- R8: System reset clears the chain and the storage register, so `sink_on` and `ser_out` are 0 until data is latched.
- R9: If `shift_clk` is held high for many cycles, the chain shifts only once.
- R10: When the `ser_out` of one instance drives the `ser_in` of a second instance that shares the same clocks, the pair acts as one chain of 2*WIDTH bits. The second instance holds the first-shifted byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every other input |
| rst_n | input | 1 | Asynchronous active-low system reset |
| shift_clk | input | 1 | Shift clock level; a rising edge advances the chain |
| latch_clk | input | 1 | Register clock level; a rising edge loads the storage register |
| ser_in | input | 1 | Serial data, sampled together with `shift_clk` |
| clr_n | input | 1 | Asynchronous active-low clear of the shift chain |
| oe_n | input | 1 | Active-low output enable |
| ser_out | output | 1 | Last chain stage, used for cascading |
| sink_on | output | WIDTH | Per-output drive; 1 = sinking (on) |

## Verification
The hardest case to reach is a shift edge and a latch edge detected in the same system cycle. Both level inputs must rise between the same pair of system clock edges. The directed part of the stimulus raises both in one step and checks that the old chain was latched. The random part of the stimulus picks the two clock rises independently, so coincident edges also occur among ordinary shifts, clears and enable toggles. A second instance is chained to the first throughout, so that every serial-output bit is checked as it lands in the next stage.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
   // one sample of the level inputs taken by the system clock
   typedef struct packed {
      logic shift_clk;
      logic latch_clk;
      logic data;
   } samp_t;

   localparam int unsigned MAX_SYNC = 4;
endpackage

// File: rtl/sipo_sampler.sv
module sipo_sampler
   import sipo_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic  clk,
   input  logic  rst_n,
   input  samp_t raw,
   output samp_t synced,
   output logic  shift_rise,
   output logic  latch_rise
);
   logic shift_prev_q;
   logic latch_prev_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign synced = raw;
      end else begin : g_sync
         samp_t pipe_q [SYNC_STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < SYNC_STAGES; i++) pipe_q[i] <= '0;
            end else begin
               pipe_q[0] <= raw;
               for (int i = 1; i < SYNC_STAGES; i++) pipe_q[i] <= pipe_q[i-1];
            end
         end
         assign synced = pipe_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shift_prev_q <= 1'b0;
         latch_prev_q <= 1'b0;
      end else begin
         shift_prev_q <= synced.shift_clk;
         latch_prev_q <= synced.latch_clk;
      end
   end

   assign shift_rise = synced.shift_clk & ~shift_prev_q;
   assign latch_rise = synced.latch_clk & ~latch_prev_q;
endmodule

// File: rtl/sipo_shift_chain.sv
module sipo_shift_chain #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_n,
   input  logic             step,
   input  logic             din,
   output logic [WIDTH-1:0] chain_q,
   output logic             dout
);
   logic             chain_rst_n;
   logic [WIDTH-1:0] chain_d;

   // system reset and clear both empty the chain asynchronously
   assign chain_rst_n = rst_n & clr_n;

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_stage
         if (i == 0) begin : g_head
            assign chain_d[i] = step ? din : chain_q[i];
         end else begin : g_body
            assign chain_d[i] = step ? chain_q[i-1] : chain_q[i];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge chain_rst_n) begin
      if (!chain_rst_n) chain_q <= '0;
      else              chain_q <= chain_d;
   end

   assign dout = chain_q[WIDTH-1];
endmodule

// File: rtl/sipo_storage.sv
module sipo_storage #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= d;
   end
endmodule

// File: rtl/sipo_out_gate.sv
module sipo_out_gate #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             oe_n,
   input  logic [WIDTH-1:0] held,
   output logic [WIDTH-1:0] drive
);
   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         assign drive[i] = held[i] & ~oe_n;
      end
   endgenerate
endmodule

// File: rtl/sipo_latch_driver.sv
module sipo_latch_driver
   import sipo_pkg::*;
#(
   parameter int unsigned WIDTH       = 8,
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift_clk,
   input  logic             latch_clk,
   input  logic             ser_in,
   input  logic             clr_n,
   input  logic             oe_n,
   output logic             ser_out,
   output logic [WIDTH-1:0] sink_on
);
   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("sipo_latch_driver: WIDTH must be at least 2");
      end
      if (SYNC_STAGES > MAX_SYNC) begin : g_bad_sync
         $error("sipo_latch_driver: SYNC_STAGES exceeds MAX_SYNC");
      end
   endgenerate

   samp_t            raw_s;
   samp_t            samp;
   logic             shift_rise;
   logic             latch_rise;
   logic [WIDTH-1:0] chain_q;
   logic [WIDTH-1:0] store_q;

   assign raw_s = '{shift_clk: shift_clk, latch_clk: latch_clk, data: ser_in};

   sipo_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
      .clk        (clk),
      .rst_n      (rst_n),
      .raw        (raw_s),
      .synced     (samp),
      .shift_rise (shift_rise),
      .latch_rise (latch_rise)
   );

   sipo_shift_chain #(.WIDTH(WIDTH)) u_chain (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_n   (clr_n),
      .step    (shift_rise),
      .din     (samp.data),
      .chain_q (chain_q),
      .dout    (ser_out)
   );

   // storage loads the pre-shift chain, so a coincident shift is not seen
   sipo_storage #(.WIDTH(WIDTH)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (latch_rise),
      .d     (chain_q),
      .q     (store_q)
   );

   sipo_out_gate #(.WIDTH(WIDTH)) u_gate (
      .oe_n  (oe_n),
      .held  (store_q),
      .drive (sink_on)
   );
endmodule

// File: rtl/sipo_latch_driver_chk.sv
module sipo_latch_driver_chk #(
   parameter int unsigned WIDTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clr_n,
   input logic             oe_n,
   input logic             shift_rise,
   input logic             latch_rise,
   input logic             data_s,
   input logic [WIDTH-1:0] chain,
   input logic [WIDTH-1:0] store,
   input logic [WIDTH-1:0] sink_on
);
   p_shift_r1: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
      shift_rise |=> chain == {$past(chain[WIDTH-2:0]), $past(data_s)});

   p_no_step_r9: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
      !shift_rise |=> $stable(chain));

   p_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
      latch_rise |=> store == $past(chain));

   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !latch_rise |=> $stable(store));

   p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_n |-> chain == '0);

   p_gate_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> sink_on == '0);

   p_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_n |-> sink_on == store);
endmodule

bind sipo_latch_driver sipo_latch_driver_chk #(.WIDTH(WIDTH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .clr_n      (clr_n),
   .oe_n       (oe_n),
   .shift_rise (shift_rise),
   .latch_rise (latch_rise),
   .data_s     (samp.data),
   .chain      (chain_q),
   .store      (store_q),
   .sink_on    (sink_on)
);

// File: tb/sipo_latch_driver_tb.sv
module sipo_latch_driver_tb;
   localparam int W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic shift_clk = 1'b0, latch_clk = 1'b0, ser_in = 1'b0;
   logic clr_n = 1'b1, oe_n = 1'b1;
   logic ser_out_a, ser_out_b;
   logic [W-1:0] sink_a, sink_b;

   int checks = 0, errors = 0;
   bit finished = 0;

   // bench model
   logic [W-1:0] m_a = '0, m_b = '0, s_a = '0, s_b = '0;

   always #2 clk = ~clk;

   sipo_latch_driver #(.WIDTH(W)) u_dut (
      .clk(clk), .rst_n(rst_n), .shift_clk(shift_clk), .latch_clk(latch_clk),
      .ser_in(ser_in), .clr_n(clr_n), .oe_n(oe_n),
      .ser_out(ser_out_a), .sink_on(sink_a));

   sipo_latch_driver #(.WIDTH(W)) u_dut_nxt (
      .clk(clk), .rst_n(rst_n), .shift_clk(shift_clk), .latch_clk(latch_clk),
      .ser_in(ser_out_a), .clr_n(clr_n), .oe_n(oe_n),
      .ser_out(ser_out_b), .sink_on(sink_b));

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [W-1:0] gated(input logic [W-1:0] s);
      return oe_n ? '0 : s;
   endfunction

   task automatic check_all(input string req);
      chk({req, " sink_a"}, 16'(sink_a), 16'(gated(s_a)));
      chk({req, " sink_b"}, 16'(sink_b), 16'(gated(s_b)));
      chk({req, " ser_out_a"}, 16'(ser_out_a), 16'(m_a[W-1]));
      chk({req, " ser_out_b"}, 16'(ser_out_b), 16'(m_b[W-1]));
   endtask

   // one pulse on the chosen clock inputs, model updated, outputs checked
   task automatic op(input bit sh, input bit la, input bit d, input string req);
      @(negedge clk);
      ser_in = d; shift_clk = sh; latch_clk = la;
      @(negedge clk);
      if (la) begin s_a = m_a; s_b = m_b; end
      if (sh && clr_n) begin
         m_b = {m_b[W-2:0], m_a[W-1]};
         m_a = {m_a[W-2:0], d};
      end
      if (!clr_n) begin m_a = '0; m_b = '0; end
      shift_clk = 1'b0; latch_clk = 1'b0;
      check_all(req);
   endtask

   task automatic load_word(input logic [15:0] v, input int n, input string req);
      for (int i = n - 1; i >= 0; i--) op(1'b1, 1'b0, v[i], req);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R8: reset state
      chk("R8 sink during reset", 16'(sink_a), 16'h0);
      chk("R8 ser_out during reset", 16'(ser_out_a), 16'h0);
      rst_n = 1'b1;
      @(negedge clk);
      oe_n = 1'b0;
      op(1'b0, 1'b1, 1'b0, "R8");
      chk("R8 latch of reset chain", 16'(sink_a), 16'h0);

      // R2: first bit reaches ser_out after W shifts
      op(1'b1, 1'b0, 1'b1, "R2");
      for (int i = 1; i < W; i++) begin
         chk("R2 not yet out", 16'(ser_out_a), 16'h0);
         op(1'b1, 1'b0, 1'b0, "R2");
      end
      chk("R2 first bit out", 16'(ser_out_a), 16'h1);

      // R1 R3 R6: shift a byte, latch, see it
      load_word(16'h00A5, W, "R1");
      op(1'b0, 1'b1, 1'b0, "R3");
      chk("R3 R6 latched byte", 16'(sink_a), 16'h00A5);

      // R5: enable high forces off, then back on
      oe_n = 1'b1; #1;
      chk("R5 outputs off", 16'(sink_a), 16'h0);
      chk("R5 second outputs off", 16'(sink_b), 16'h0);
      oe_n = 1'b0; #1;
      chk("R6 outputs restored", 16'(sink_a), 16'h00A5);

      // R4: asynchronous clear; storage untouched; shifts ignored
      @(negedge clk);
      clr_n = 1'b0; #1;
      m_a = '0; m_b = '0;
      chk("R4 ser_out cleared without clock", 16'(ser_out_a), 16'h0);
      chk("R4 storage kept", 16'(sink_a), 16'h00A5);
      op(1'b1, 1'b0, 1'b1, "R4 shift under clear");
      clr_n = 1'b1;
      op(1'b0, 1'b1, 1'b0, "R4");
      chk("R4 chain empty after clear", 16'(sink_a), 16'h0);

      // R7: coincident edges latch the pre-shift chain
      load_word(16'h003C, W, "R7 load");
      op(1'b1, 1'b1, 1'b1, "R7");
      chk("R7 pre-shift value latched", 16'(sink_a), 16'h003C);
      op(1'b0, 1'b1, 1'b0, "R7");
      chk("R7 shifted value next latch", 16'(sink_a), 16'h0079);

      // R9: shift clock held high shifts once
      @(negedge clk); clr_n = 1'b0; @(negedge clk); clr_n = 1'b1;
      m_a = '0; m_b = '0;
      @(negedge clk);
      ser_in = 1'b1; shift_clk = 1'b1;
      repeat (6) @(negedge clk);
      shift_clk = 1'b0;
      m_b = {m_b[W-2:0], m_a[W-1]};
      m_a = {m_a[W-2:0], 1'b1};
      op(1'b0, 1'b1, 1'b0, "R9");
      chk("R9 single shift", 16'(sink_a), 16'h0001);

      // R10: two chained instances form a 16-bit chain
      load_word(16'hBEEF, 2 * W, "R10 load");
      op(1'b0, 1'b1, 1'b0, "R10");
      chk("R10 upper byte in second", 16'(sink_b), 16'h00BE);
      chk("R10 lower byte in first", 16'(sink_a), 16'h00EF);

      // random mix of shifts, latches, clears and enables
      for (int n = 0; n < 400; n++) begin
         int unsigned r = $urandom % 16;
         if (r == 0) begin
            @(negedge clk); clr_n = 1'b0; #1;
            m_a = '0; m_b = '0;
            check_all("R4 random clear");
            @(negedge clk); clr_n = 1'b1;
         end else if (r == 1) begin
            oe_n = ~oe_n; #1;
            check_all("R5 R6 random enable");
         end else begin
            op(1'($urandom % 2), 1'($urandom % 4 == 0), 1'($urandom % 2), "R1 R3 R7 random");
         end
      end

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule